// File: doc/BRIEF.md
# Trace Buffer Read Window

This block holds a small array of 64-bit trace lines and lets a bus master read them out through a single 16-bit register window. Each accepted read returns one 16-bit slice. A line is returned most significant slice first, so four reads give one whole line. An internal pointer then moves on to the next slice, or to the first slice of the next line. A separate write port fills lines directly and is used to load known content for test.

Readout is guarded by a lock. The lock is set while the arm input is high. It is cleared only by a full 16-bit write to the window address made while arm is low. That write resets the pointer and leaves the stored lines as they were; the write data is not stored, so the slave port carries no write-data bus.

A read of the window is accepted only when all of the following hold:
- the lock is clear;
- arm is low;
- secure is low;
- at least one trace-source enable bit is set;
- both byte enables are set and the access is at the even window address.

Any other read gets zero a cycle later and leaves the pointer where it was. Every access completes in one cycle.

Top module: `tbuf_window`

## Requirements
- R1: After a synchronous reset, `bus_rdata` is 0, the lock is clear and the pointer is at slice 0 of line 0. The first valid read after reset therefore returns bits [63:48] of line 0.
- R2: A valid read returns its slice on `bus_rdata` in the cycle after the read strobe. A valid read is `bus_rd`=1 with `bus_wr`=0, `bus_addr`=WIN_ADDR and `bus_be`=2'b11, while the lock is clear, arm=0, secure=0 and `src_en`!=0. Slices of a line come out in the order [63:48], [47:32], [31:16], [15:0], and lines come out in ascending index order.
- R3: After slice [15:0] of line DEPTH-1 is read, the next valid read returns slice [63:48] of line 0.
- R4: While arm=1 the lock is set, and it stays set after arm returns to 0. Reads made while arm=1 or while locked return 0 and do not move the pointer.
- R5: A write with `bus_addr`=WIN_ADDR, `bus_be`=2'b11 and arm=0 clears the lock and returns the pointer to slice 0 of line 0. This holds whether or not the lock was set, and the stored lines are unchanged.
- R6: A window write made while arm=1, or a write with `bus_be`!=2'b11, leaves the lock set.
- R7: A read with `bus_be`!=2'b11, or a read at WIN_ADDR+1, returns 0 and does not move the pointer.
- R8: A read made with secure=1, or with `src_en`=0, returns 0 and does not move the pointer.
- R9: Reset does not alter the stored lines.
- R10: In any cycle that does not follow a valid read, `bus_rdata` is 0. No access ever stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (does not touch the stored lines) |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_be | input | 2 | Byte enables; 2'b11 means a full 16-bit access |
| bus_rdata | output | WIN_W | Read data, valid the cycle after the read strobe |
| arm | input | 1 | Arm control; a high level sets the lock |
| secure | input | 1 | Secured-device state; high blocks readout |
| src_en | input | SRC_W | Trace-source enables; at least one must be set to read |
| tw_en | input | 1 | Test write enable for the line store |
| tw_idx | input | $clog2(DEPTH) | Line index for the test write |
| tw_data | input | LINE_W | Line data for the test write |

## Verification
The bench builds the block with its default values: 16 lines of 64 bits, a 16-bit window at address 0x24 and four source-enable bits. With these values a complete pass of 64 reads reaches the wrap from the last slice of line 15 back to line 0, which exercises the pointer boundary. Rejected reads of each kind are placed between valid reads, so a wrongly advanced pointer shows up in the next slice returned. The unlock write and the reset are each followed by reads of known lines, which shows that the pointer restarts and the stored contents survive.

// File: rtl/tbw_pkg.sv
package tbw_pkg;

    typedef struct packed {
        logic rd_ok;
        logic rd_bad;
        logic unlock;
    } tbw_acc_t;

    function automatic logic full_word(input logic [1:0] be);
        return be == 2'b11;
    endfunction

endpackage

// File: rtl/tbw_decode.sv
module tbw_decode
    import tbw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SRC_W = 4,
    parameter logic [ADDR_W-1:0] WIN_ADDR = 8'h24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_be,
    input  logic              arm,
    input  logic              secure,
    input  logic [SRC_W-1:0]  src_en,
    input  logic              locked,
    output tbw_acc_t          acc
);
    logic hit_word;
    logic read_gate;

    always_comb begin
        hit_word  = (bus_addr == WIN_ADDR) && full_word(bus_be);
        read_gate = !locked && !arm && !secure && (|src_en);
        acc.rd_ok  = bus_rd && !bus_wr && hit_word && read_gate;
        acc.rd_bad = bus_rd && !acc.rd_ok;
        acc.unlock = bus_wr && hit_word && !arm;
    end

    a_r8_secure_blocks: assert property (@(posedge clk) disable iff (rst)
        (secure || src_en == '0) |-> !acc.rd_ok);

    a_r7_size_blocks: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_be != 2'b11 || bus_addr == WIN_ADDR + 1'b1)) |-> acc.rd_bad);

endmodule

// File: rtl/tbw_store.sv
module tbw_store #(
    parameter int DEPTH = 16,
    parameter int LINE_W = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              tw_en,
    input  logic [IDX_W-1:0]  tw_idx,
    input  logic [LINE_W-1:0] tw_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_line
);
    logic [LINE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (tw_en) mem[tw_idx] <= tw_data;
    end

    assign rd_line = mem[rd_idx];

endmodule

// File: rtl/tbw_ptr.sv
module tbw_ptr
    import tbw_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int SLICES = 4,
    localparam int TOTAL = DEPTH * SLICES,
    localparam int PTR_W = $clog2(TOTAL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  tbw_acc_t         acc,
    output logic             locked,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(TOTAL - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b0;
            ptr    <= '0;
        end else begin
            if (arm)             locked <= 1'b1;
            else if (acc.unlock) locked <= 1'b0;

            if (acc.unlock)     ptr <= '0;
            else if (acc.rd_ok) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    a_r4_arm_locks: assert property (@(posedge clk) disable iff (rst)
        arm |=> locked);

    a_r7_bad_read_holds: assert property (@(posedge clk) disable iff (rst)
        (acc.rd_bad && !acc.unlock) |=> $stable(ptr));

    a_r5_unlock_rewinds: assert property (@(posedge clk) disable iff (rst)
        acc.unlock |=> (!locked && ptr == '0));

    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (acc.rd_ok && ptr == LAST) |=> ptr == '0);

    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (acc.rd_ok && ptr != LAST) |=> ptr == $past(ptr) + 1'b1);

endmodule

// File: rtl/tbuf_window.sv
module tbuf_window
    import tbw_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LINE_W = 64,
    parameter int WIN_W = 16,
    parameter int ADDR_W = 8,
    parameter int SRC_W = 4,
    parameter logic [ADDR_W-1:0] WIN_ADDR = 8'h24,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int SLICES = LINE_W / WIN_W,
    localparam int SL_W = $clog2(SLICES),
    localparam int PTR_W = $clog2(DEPTH * SLICES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_be,
    output logic [WIN_W-1:0]  bus_rdata,
    input  logic              arm,
    input  logic              secure,
    input  logic [SRC_W-1:0]  src_en,
    input  logic              tw_en,
    input  logic [IDX_W-1:0]  tw_idx,
    input  logic [LINE_W-1:0] tw_data
);
    tbw_acc_t          acc;
    logic              locked;
    logic [PTR_W-1:0]  ptr;
    logic [LINE_W-1:0] line;
    logic [WIN_W-1:0]  slice_arr [SLICES];

    tbw_decode #(.ADDR_W(ADDR_W), .SRC_W(SRC_W), .WIN_ADDR(WIN_ADDR)) u_dec (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_be(bus_be), .arm(arm), .secure(secure),
        .src_en(src_en), .locked(locked), .acc(acc)
    );

    tbw_ptr #(.DEPTH(DEPTH), .SLICES(SLICES)) u_ptr (
        .clk(clk), .rst(rst), .arm(arm), .acc(acc), .locked(locked), .ptr(ptr)
    );

    tbw_store #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_store (
        .clk(clk), .tw_en(tw_en), .tw_idx(tw_idx), .tw_data(tw_data),
        .rd_idx(ptr[PTR_W-1:SL_W]), .rd_line(line)
    );

    for (genvar g = 0; g < SLICES; g++) begin : g_slice
        assign slice_arr[g] = line[LINE_W-1-g*WIN_W -: WIN_W];
    end

    always_ff @(posedge clk) begin
        if (rst)            bus_rdata <= '0;
        else if (acc.rd_ok) bus_rdata <= slice_arr[ptr[SL_W-1:0]];
        else                bus_rdata <= '0;
    end

    a_r10_zero_otherwise: assert property (@(posedge clk) disable iff (rst)
        !acc.rd_ok |=> bus_rdata == '0);

    a_r4_locked_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (locked || arm)) |=> bus_rdata == '0);

endmodule

// File: tb/sim_tbuf_window.sv
module sim_tbuf_window;
    logic        clk = 0;
    logic        rst = 1;
    logic [7:0]  bus_addr = 8'h24;
    logic        bus_rd = 0, bus_wr = 0;
    logic [1:0]  bus_be = 2'b11;
    logic [15:0] bus_rdata;
    logic        arm = 0, secure = 0;
    logic [3:0]  src_en = 4'b0001;
    logic        tw_en = 0;
    logic [3:0]  tw_idx = 0;
    logic [63:0] tw_data = 0;

    int checks = 0, fails = 0, mptr = 0;
    bit done = 0;
    logic [63:0] mem_m [16];

    always #5 clk = ~clk;

    tbuf_window u0 (.*);

    function automatic logic [63:0] pat(input int i);
        return 64'hA55A_0F0F_3C3C_9669 ^ (64'(i) * 64'h0123_4567_89AB_CDEF);
    endfunction

    function automatic logic [15:0] exp_slice(input int p);
        logic [63:0] l = mem_m[p / 4];
        return l[63 - 16 * (p % 4) -: 16];
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] be, output logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_be = be; bus_rd = 1;
        @(negedge clk); d = bus_rdata; bus_rd = 0; bus_addr = 8'h24; bus_be = 2'b11;
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] be);
        @(negedge clk); bus_addr = a; bus_be = be; bus_wr = 1;
        @(negedge clk); bus_wr = 0; bus_addr = 8'h24; bus_be = 2'b11;
    endtask

    task automatic good_rd(input string tag);
        logic [15:0] d;
        rd(8'h24, 2'b11, d);
        chk(tag, d, exp_slice(mptr));
        mptr = (mptr + 1) % 64;
    endtask

    task automatic bad_rd(input string tag, input logic [7:0] a, input logic [1:0] be);
        logic [15:0] d;
        rd(a, be, d);
        chk(tag, d, 16'h0);
    endtask

    task automatic t_reset;
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        chk("R1 rdata after reset", bus_rdata, 16'h0);
        mptr = 0;
    endtask

    task automatic t_fill;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); tw_en = 1; tw_idx = 4'(i); tw_data = pat(i); mem_m[i] = pat(i);
        end
        @(negedge clk); tw_en = 0;
    endtask

    task automatic t_order;
        for (int i = 0; i < 8; i++) good_rd("R2 slice order");
        @(negedge clk);
        chk("R10 idle rdata", bus_rdata, 16'h0);
    endtask

    task automatic t_wrap;
        while (mptr != 0) good_rd("R3 full pass");
        good_rd("R3 wrap to line0 slice0");
        good_rd("R3 after wrap");
    endtask

    task automatic t_size;
        bad_rd("R7 low byte read", 8'h24, 2'b01);
        bad_rd("R7 high byte read", 8'h24, 2'b10);
        bad_rd("R7 misaligned read", 8'h25, 2'b11);
        good_rd("R7 pointer held");
    endtask

    task automatic t_gate;
        secure = 1; bad_rd("R8 secure read", 8'h24, 2'b11); secure = 0;
        src_en = 0; bad_rd("R8 no source read", 8'h24, 2'b11); src_en = 4'b1000;
        good_rd("R8 pointer held");
    endtask

    task automatic t_arm;
        @(negedge clk); arm = 1;
        bad_rd("R4 armed read", 8'h24, 2'b11);
        wr(8'h24, 2'b11);
        arm = 0;
        bad_rd("R4 locked after disarm", 8'h24, 2'b11);
        bad_rd("R6 armed write kept lock", 8'h24, 2'b11);
        wr(8'h24, 2'b01);
        bad_rd("R6 byte write kept lock", 8'h24, 2'b11);
        wr(8'h24, 2'b11);
        mptr = 0;
        good_rd("R5 unlock rewinds, data intact");
        good_rd("R5 second slice");
        good_rd("R4 pointer held while locked");
        wr(8'h24, 2'b11);
        mptr = 0;
        good_rd("R5 rewind while unlocked");
    endtask

    task automatic t_reset_keep;
        for (int i = 0; i < 9; i++) good_rd("R2 advance");
        t_reset;
        good_rd("R9 contents kept, R1 pointer at 0");
        good_rd("R9 second slice kept");
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset;
        t_fill;
        t_order;
        t_wrap;
        t_size;
        t_gate;
        t_arm;
        t_reset_keep;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule